// File: doc/BRIEF.md
# Buck Converter Gate Sequencer with Pulse Skipping

This block is the digital cycle controller of a fixed-frequency, peak-current-mode step-down converter. It divides a fast system clock into switching periods and produces the high-side and low-side gate enables. The analog comparators (current ramp against the error amplifier output, high-side current limit, inductor zero crossing, output above set point) reach it as single-bit inputs.

In forced-PWM mode every period starts with the high side on. The high side stays on until a comparator trips or a maximum duty count is reached. After a dead gap the low side conducts until shortly before the period ends.

In skip mode a period starts with both switches off when the output is above its set point. Otherwise the period starts with a fixed-width on-pulse. The low side is also dropped as soon as the inductor current reaches zero, so no negative current can flow. The mode is captured when the block is enabled and cannot change while it runs.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst_n` is low, or from the cycle after `enable` is sampled low, `hs_gate` and `ls_gate` are both 0 and all period state restarts.
- R2: While running, a period lasts PERIOD (100) cycles, and in forced-PWM mode `hs_gate` is 1 in the first cycle of every period.
- R3: In forced-PWM mode, `hs_gate` falls in the cycle after it is high together with `ramp_trip`. In either mode, `hs_gate` falls in the cycle after it is high together with `ilim`.
- R4: `hs_gate` is never high for more than MAX_ON (95) consecutive cycles of a forced-PWM period. With no trip it is high for exactly MAX_ON cycles.
- R5: `ls_gate` rises exactly DEAD (2) cycles after `hs_gate` falls, and only if that cycle lies before cycle PERIOD-DEAD of the period. It is low from cycle PERIOD-DEAD to the end of the period, so at least DEAD low cycles separate either gate falling from the other rising.
- R6: `hs_gate` and `ls_gate` are never both 1.
- R7: In skip mode, when `out_high` is 1 at the edge that starts a period, both gates stay 0 for the whole period.
- R8: In skip mode, when `out_high` is 0 at the period start, `hs_gate` is high for exactly SKIP_ON (33) cycles unless `ilim` ends it earlier. `ramp_trip` has no effect.
- R9: In skip mode, `ls_gate` falls in the cycle after it is high together with `zero_cross`, and stays 0 for the rest of the period. In forced-PWM mode `zero_cross` has no effect.
- R10: `skip_sel` (1 = skip, 0 = forced PWM) is sampled in the cycle in which `enable` is first seen high. Changes while enabled have no effect.
- R11: The first period begins two cycles after `enable` is first sampled high: `hs_gate` rises at the second clock edge after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the converter when 1 |
| skip_sel | input | 1 | Mode request: 1 skip, 0 forced PWM |
| ramp_trip | input | 1 | Current ramp has crossed the error amplifier output |
| ilim | input | 1 | High-side current limit reached |
| zero_cross | input | 1 | Inductor current below the zero-crossing threshold |
| out_high | input | 1 | Output voltage above set point |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
The hardest situation to reach is a high-side pulse that ends so late that the dead gap runs into the end-of-period guard. In that case the low side gets a single cycle or is skipped entirely. The stimulus reaches it with forced-PWM periods that run to the full duty limit, and with long random runs in which trip events land at every position of the period. Skip-mode periods with and without a pulse, and mode changes made while running, are driven in directed phases; the behavioural model compares both gates on every cycle of these phases.

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int PERIOD  = 100,
  parameter int MAX_ON  = 95,
  parameter int SKIP_ON = 33,
  parameter int DEAD    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic skip_sel,
  input  logic ramp_trip,
  input  logic ilim,
  input  logic zero_cross,
  input  logic out_high,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int CW = $clog2(PERIOD);
  localparam int DW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LIM_PWM = CW'(MAX_ON - 1);
  localparam logic [CW-1:0] LIM_SKP = CW'(SKIP_ON - 1);
  localparam logic [CW-1:0] LS_END  = CW'(PERIOD - DEAD - 1);
  localparam logic [DW-1:0] D_END   = DW'(DEAD - 1);

  logic          running, skip_m, pend;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dc;

  wire           wrap   = (cnt == LAST);
  wire [CW-1:0]  on_lim = skip_m ? LIM_SKP : LIM_PWM;
  wire           fire   = !skip_m || !out_high;
  wire           hs_end = hs_gate && (ilim || (ramp_trip && !skip_m) || cnt == on_lim);
  wire           ls_end = ls_gate && (cnt == LS_END || (skip_m && zero_cross));
  wire           ls_go  = pend && (dc == D_END);
  wire           room   = (cnt < LS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; skip_m <= 1'b0; cnt <= '0;
      hs_gate <= 1'b0; ls_gate <= 1'b0; pend <= 1'b0; dc <= '0;
    end else if (!enable) begin
      running <= 1'b0; skip_m <= 1'b0; cnt <= '0;
      hs_gate <= 1'b0; ls_gate <= 1'b0; pend <= 1'b0; dc <= '0;
    end else if (!running) begin
      running <= 1'b1; skip_m <= skip_sel; cnt <= LAST;
      hs_gate <= 1'b0; ls_gate <= 1'b0; pend <= 1'b0; dc <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        hs_gate <= fire;
        ls_gate <= 1'b0;
        pend    <= 1'b0;
        dc      <= '0;
      end else begin
        if (hs_end) begin
          hs_gate <= 1'b0;
          pend    <= 1'b1;
          dc      <= '0;
        end else if (ls_go) begin
          pend    <= 1'b0;
          ls_gate <= room;
        end else if (pend) begin
          dc <= dc + 1'b1;
        end
        if (ls_end) ls_gate <= 1'b0;
      end
    end
  end
endmodule

module buck_gate_seq_chk #(
  parameter int MAX_ON = 95,
  parameter int DEAD   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic hs_gate,
  input logic ls_gate
);
  logic [7:0] hs_lo, ls_lo, hs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_lo <= 8'(DEAD); ls_lo <= 8'(DEAD); hs_run <= '0;
    end else begin
      hs_lo  <= hs_gate ? '0 : (hs_lo == 8'hFF ? hs_lo : hs_lo + 1'b1);
      ls_lo  <= ls_gate ? '0 : (ls_lo == 8'hFF ? ls_lo : ls_lo + 1'b1);
      hs_run <= hs_gate ? (hs_run == 8'hFF ? hs_run : hs_run + 1'b1) : '0;
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  assert_dead_before_ls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> hs_lo >= 8'(DEAD));
  assert_dead_before_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ls_lo >= 8'(DEAD));
  assert_max_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> hs_run < 8'(MAX_ON));
  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_gate && !ls_gate));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(.MAX_ON(MAX_ON), .DEAD(DEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hs_gate(hs_gate), .ls_gate(ls_gate));

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int P = 100, MX = 95, SK = 33, D = 2;

  logic clk = 0, rst_n = 0, enable = 0, skip_sel = 0;
  logic ramp_trip = 0, ilim = 0, zero_cross = 0, out_high = 0;
  logic hs_gate, ls_gate;

  buck_gate_seq #(.PERIOD(P), .MAX_ON(MX), .SKIP_ON(SK), .DEAD(D)) i_buck_gate_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .skip_sel(skip_sel),
    .ramp_trip(ramp_trip), .ilim(ilim), .zero_cross(zero_cross),
    .out_high(out_high), .hs_gate(hs_gate), .ls_gate(ls_gate));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit cmp_on = 0;

  // behavioural reference
  bit m_run, m_sk, m_hs, m_ls, m_blk;
  int m_pos, m_fall;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !enable) begin
      m_run = 0; m_hs = 0; m_ls = 0; m_pos = 0; m_fall = -1; m_blk = 0;
    end else if (!m_run) begin
      m_run = 1; m_sk = skip_sel; m_pos = P - 1; m_hs = 0; m_ls = 0; m_fall = -1; m_blk = 0;
    end else begin
      int np; bit nh, nl;
      np = (m_pos == P - 1) ? 0 : m_pos + 1;
      nh = m_hs; nl = m_ls;
      if (np == 0) begin
        nh = m_sk ? !out_high : 1'b1; nl = 0; m_fall = -1; m_blk = 0;
      end else begin
        if (m_hs && (ilim || (ramp_trip && !m_sk) || m_pos == (m_sk ? SK : MX) - 1)) begin
          nh = 0; m_fall = np;
        end
        if (m_ls && (np == P - D || (m_sk && zero_cross))) begin
          nl = 0; m_blk = 1;
        end else if (!m_ls && !m_blk && m_fall >= 0 && np == m_fall + D) begin
          nl = (np < P - D); m_blk = 1;
        end
      end
      m_hs = nh; m_ls = nl; m_pos = np;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    checks++;
    if (hs_gate !== m_hs || ls_gate !== m_ls) begin
      errors++;
      $display("FAIL %s cycle %0d: hs/ls actual %b%b expected %b%b", tag, cycles, hs_gate, ls_gate, m_hs, m_ls);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(input string req, input int n, input int exp_hs, input int exp_ls);
    int h = 0, l = 0;
    tag = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += hs_gate; l += ls_gate;
    end
    check({req, " high-side cycles"}, h, exp_hs);
    check({req, " low-side cycles"}, l, exp_ls);
  endtask

  task automatic rnd(input string req, input int n, input int pr, input int pi, input int pz, input int ph);
    tag = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ramp_trip  = ($urandom_range(0, 99) < pr);
      ilim       = ($urandom_range(0, 99) < pi);
      zero_cross = ($urandom_range(0, 99) < pz);
      out_high   = ($urandom_range(0, 99) < ph);
    end
    ramp_trip = 0; ilim = 0; zero_cross = 0; out_high = 0;
  endtask

  task automatic start(input bit sk);
    @(negedge clk); enable = 0; skip_sel = sk;
    @(negedge clk); enable = 1;
  endtask

  initial begin
    idle(3);
    check("R1 reset hs", hs_gate, 0);
    check("R1 reset ls", ls_gate, 0);
    rst_n = 1; cmp_on = 1;
    idle(2);
    // R11 start latency
    tag = "R11"; enable = 1; skip_sel = 0;
    @(negedge clk); check("R11 hs before first period", hs_gate, 0);
    @(negedge clk); check("R11 hs at first period", hs_gate, 1);
    idle(200);
    window("R2 R4 R5 forced PWM full duty", 300, 3 * MX, 3);
    rnd("R3 R9 forced PWM random trips", 3000, 4, 1, 10, 50);
    idle(200);
    // R10: mode change while running ignored
    skip_sel = 1; out_high = 1;
    idle(200);
    window("R10 mode change ignored", 300, 3 * MX, 3);
    zero_cross = 1;
    window("R9 zero_cross ignored in PWM", 300, 3 * MX, 3);
    zero_cross = 0;
    // R1 disable mid-period
    tag = "R1";
    @(negedge clk); enable = 0;
    @(negedge clk); check("R1 hs after disable", hs_gate, 0);
    check("R1 ls after disable", ls_gate, 0);
    idle(5);
    // skip mode
    out_high = 1; start(1);
    idle(200);
    window("R7 skip idle periods", 300, 0, 0);
    out_high = 0; ramp_trip = 1;
    idle(200);
    window("R8 skip fixed pulse, ramp ignored", 300, 3 * SK, 3 * (P - D - SK - D));
    ramp_trip = 0; zero_cross = 1;
    idle(200);
    window("R9 skip zero crossing", 300, 3 * SK, 3);
    zero_cross = 0;
    rnd("R8 R9 R7 skip random", 4000, 5, 2, 8, 50);
    // R10: re-enable picks up new mode
    out_high = 1; start(0);
    idle(200);
    window("R10 re-enable forced PWM", 300, 3 * MX, 3);
    // random bursts with mode and enable changes
    for (int b = 0; b < 20; b++) begin
      start($urandom_range(0, 1));
      rnd("R3 R5 R6 random burst", $urandom_range(50, 800), 3, 2, 6, 50);
    end
    @(negedge clk); enable = 0;
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule